// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block takes a serial E1 receive stream, one bit per clock when `bitEn` is high, and locks onto the basic frame. A frame is 32 time slots of 8 bits, so 256 bits long. Every bit position is a possible alignment. The block scans for the seven-bit alignment word in time slot 0 of a candidate frame. It then checks the two frames that follow before it declares lock, and once locked it watches the alignment words for loss of lock.

While the block is locked it gives a strobe at the start of each frame and a flag that marks whether the current frame carries the alignment word. The loss-of-sync output is the complement of the lock flag.

A mode input `altMode` adds a second rule for loss of lock. With it set, repeated errors in bit 2 of the frames that do not carry the alignment word also cause a fresh search. When `altMode` is clear, only errors in the alignment word count.

Top module: `e1_frame_aligner`

## Requirements
- R1: During and just after reset, `inSync`=0, `lossOfSync`=1, `frameStart`=0 and `fasFrame`=0.
- R2: Bits arrive first-transmitted first, and bit 1 of time slot 0 is ignored for alignment. A frame carries the alignment word when bits 2 to 8 of its time slot 0 are 0,0,1,1,0,1,1. The other frames must carry 1 in bit 2. Lock is declared only after three frames in a row: alignment word in frame N, bit 2 = 1 in frame N+1, and the alignment word in frame N+2. `inSync` rises on the clock edge that takes bit 8 of time slot 0 of frame N+2.
- R3: If bit 2 is 0 in frame N+1, that candidate is dropped. The search restarts at the next bit, and lock then needs a new frame N.
- R4: If the alignment word is missing in frame N+2, that candidate is dropped and the search restarts at the next bit.
- R5: While locked, three alignment-word frames in a row received with a wrong word drop the lock. `inSync` falls on the edge that takes bit 8 of time slot 0 of the third bad frame.
- R6: A correctly received word clears its consecutive-error count, so two bad words, a good one and two more bad ones keep the lock.
- R7: With `altMode`=0, bit-2 errors in the frames without the alignment word never drop the lock.
- R8: With `altMode`=1, three such frames in a row with bit 2 = 0 drop the lock. `inSync` falls on the edge that takes bit 8 of time slot 0 of the third bad frame.
- R9: While locked, `frameStart` pulses for one cycle after the edge that takes bit 1 of time slot 0. While locked, `fasFrame` is 1 during frames that carry the alignment word and 0 during the others.
- R10: `lossOfSync` is always the complement of `inSync`.
- R11: A cycle with `bitEn`=0 takes no bit. During it `inSync` holds and `frameStart` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | A received bit is present on `rxBit` this cycle |
| rxBit | input | 1 | Received serial data bit |
| altMode | input | 1 | 1 adds bit-2 errors in frames without the alignment word as a loss-of-lock rule |
| inSync | output | 1 | Basic frame alignment held |
| lossOfSync | output | 1 | Alignment not held |
| frameStart | output | 1 | One-cycle strobe for bit 1 of time slot 0 while locked |
| fasFrame | output | 1 | Current frame carries the alignment word (valid while locked) |

## Verification
A wrong bit-position count or a wrong frame parity shows at the ports within one frame as a misplaced `frameStart` or an inverted `fasFrame`. A wrong confirm or loss state shows as `inSync` changing 256 bits early or late. The bench compares every output after every taken bit and every idle cycle against a model of the stream, so any such fault is reported within 256 bits of where it arises. It sweeps the start offset, both settings of `altMode`, failures at each confirm step, consecutive and interrupted error runs, and idle cycles.

// File: rtl/e1fa_pkg.sv
`timescale 1ns/1ps
package e1fa_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH   = 2'd0,
    ST_CONF_NFAS = 2'd1,
    ST_CONF_FAS = 2'd2,
    ST_SYNC     = 2'd3
  } e1fa_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic alignLoad;  // candidate found: the bit just taken is bit 8 of TS0
    logic inSync;
  } e1fa_ctrl_t;

  // datapath -> control status
  typedef struct packed {
    logic bitTaken;
    logic checkPoint; // bit being taken is bit 8 of TS0 at current alignment
    logic fasMatch;   // window ending with this bit equals the alignment word
    logic bit2One;    // bit 2 of TS0 in the window is 1
    logic curFas;     // frame of the bit being taken carries the alignment word
  } e1fa_stat_t;

endpackage

// File: rtl/e1fa_errcount.sv
`timescale 1ns/1ps
module e1fa_errcount #(
  parameter int LIMIT = 3,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             evalGood,
  input  logic             evalBad,
  output logic [CNT_W-1:0] cnt,
  output logic             limitHit
);

  always_comb limitHit = evalBad && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clear || evalGood || limitHit) begin
      cnt <= '0;
    end else if (evalBad) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/e1fa_datapath.sv
`timescale 1ns/1ps
module e1fa_datapath
  import e1fa_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int NUM_SLOTS = 32,
  parameter logic [SLOT_BITS-2:0] FAS_WORD = 7'b0011011,
  localparam int FRAME_BITS = SLOT_BITS * NUM_SLOTS,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int FAS_LEN = SLOT_BITS - 1,
  localparam int CHECK_POS = SLOT_BITS - 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxBit,
  input  e1fa_ctrl_t ctrl,
  output e1fa_stat_t stat,
  output logic       frameStart
);

  logic [FAS_LEN-2:0] shReg;
  logic [FAS_LEN-1:0] window;
  logic [POS_W-1:0]   pos;
  logic               curFas;
  logic               posWrap;

  always_comb begin
    window          = {shReg, rxBit};
    posWrap         = (pos == POS_W'(FRAME_BITS - 1));
    stat.bitTaken   = bitEn;
    stat.checkPoint = bitEn && (pos == POS_W'(CHECK_POS - 1));
    stat.fasMatch   = (window == FAS_WORD);
    stat.bit2One    = window[FAS_LEN-1];
    stat.curFas     = curFas;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '1;
    end else if (bitEn) begin
      shReg <= {shReg[FAS_LEN-3:0], rxBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos    <= '0;
      curFas <= 1'b0;
    end else if (bitEn) begin
      if (ctrl.alignLoad) begin
        pos    <= POS_W'(CHECK_POS);
        curFas <= 1'b1;
      end else if (posWrap) begin
        pos    <= '0;
        curFas <= ~curFas;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameStart <= 1'b0;
    end else begin
      frameStart <= bitEn && posWrap && ctrl.inSync;
    end
  end

endmodule

// File: rtl/e1fa_control.sv
`timescale 1ns/1ps
module e1fa_control
  import e1fa_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  localparam int CNT_W = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             altMode,
  input  e1fa_stat_t       stat,
  output e1fa_ctrl_t       ctrl,
  output logic [CNT_W-1:0] fasErrCnt,
  output logic [CNT_W-1:0] nfasErrCnt
);

  e1fa_state_e state, stateNext;
  logic syncCheck, fasEval, nfasEval;
  logic fasGood, fasBad, nfasGood, nfasBad;
  logic fasClear, nfasClear, fasHit, nfasHit;

  always_comb begin
    syncCheck = (state == ST_SYNC) && stat.checkPoint;
    fasEval   = syncCheck && stat.curFas;
    nfasEval  = syncCheck && !stat.curFas && altMode;
    fasGood   = fasEval && stat.fasMatch;
    fasBad    = fasEval && !stat.fasMatch;
    nfasGood  = nfasEval && stat.bit2One;
    nfasBad   = nfasEval && !stat.bit2One;
    fasClear  = (state != ST_SYNC);
    nfasClear = (state != ST_SYNC) || (syncCheck && !stat.curFas && !altMode);
  end

  e1fa_errcount #(.LIMIT(ERR_LIMIT)) u_fasCnt (
    .clk(clk), .rstN(rstN), .clear(fasClear),
    .evalGood(fasGood), .evalBad(fasBad),
    .cnt(fasErrCnt), .limitHit(fasHit)
  );

  e1fa_errcount #(.LIMIT(ERR_LIMIT)) u_nfasCnt (
    .clk(clk), .rstN(rstN), .clear(nfasClear),
    .evalGood(nfasGood), .evalBad(nfasBad),
    .cnt(nfasErrCnt), .limitHit(nfasHit)
  );

  always_comb begin
    stateNext      = state;
    ctrl.alignLoad = 1'b0;
    unique case (state)
      ST_SEARCH: begin
        if (stat.bitTaken && stat.fasMatch) begin
          ctrl.alignLoad = 1'b1;
          stateNext      = ST_CONF_NFAS;
        end
      end
      ST_CONF_NFAS: begin
        if (stat.checkPoint) stateNext = stat.bit2One ? ST_CONF_FAS : ST_SEARCH;
      end
      ST_CONF_FAS: begin
        if (stat.checkPoint) stateNext = stat.fasMatch ? ST_SYNC : ST_SEARCH;
      end
      ST_SYNC: begin
        if (fasHit || nfasHit) stateNext = ST_SEARCH;
      end
      default: stateNext = ST_SEARCH;
    endcase
    ctrl.inSync = (state == ST_SYNC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SEARCH;
    else       state <= stateNext;
  end

endmodule

// File: rtl/e1_frame_aligner.sv
`timescale 1ns/1ps
module e1_frame_aligner
  import e1fa_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int NUM_SLOTS = 32,
  parameter int ERR_LIMIT = 3,
  parameter logic [SLOT_BITS-2:0] FAS_WORD = 7'b0011011
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic rxBit,
  input  logic altMode,
  output logic inSync,
  output logic lossOfSync,
  output logic frameStart,
  output logic fasFrame
);

  localparam int CNT_W = $clog2(ERR_LIMIT + 1);

  e1fa_ctrl_t       ctrl;
  e1fa_stat_t       stat;
  logic [CNT_W-1:0] fasErrCnt;
  logic [CNT_W-1:0] nfasErrCnt;

  e1fa_datapath #(
    .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .FAS_WORD(FAS_WORD)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit),
    .ctrl(ctrl), .stat(stat), .frameStart(frameStart)
  );

  e1fa_control #(.ERR_LIMIT(ERR_LIMIT)) u_control (
    .clk(clk), .rstN(rstN), .altMode(altMode), .stat(stat),
    .ctrl(ctrl), .fasErrCnt(fasErrCnt), .nfasErrCnt(nfasErrCnt)
  );

  always_comb begin
    inSync     = ctrl.inSync;
    lossOfSync = ~ctrl.inSync;
    fasFrame   = ctrl.inSync & stat.curFas;
  end

endmodule

// File: rtl/e1_frame_aligner_chk.sv
`timescale 1ns/1ps
module e1_frame_aligner_chk #(
  parameter int ERR_LIMIT = 3,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitEn,
  input logic             altMode,
  input logic             inSync,
  input logic             lossOfSync,
  input logic             frameStart,
  input logic             fasFrame,
  input logic [CNT_W-1:0] fasErrCnt,
  input logic [CNT_W-1:0] nfasErrCnt
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_start_in_sync_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> inSync);

  assert_parity_at_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && inSync && $past(inSync) && !$stable(fasFrame)) |-> frameStart);

  assert_lock_on_fas_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(inSync)) |-> (fasFrame && $past(bitEn)));

  assert_loss_on_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(lossOfSync)) |-> $past(bitEn));

  assert_fas_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fasErrCnt < CNT_W'(ERR_LIMIT));

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && fasErrCnt > $past(fasErrCnt)) |-> (fasErrCnt == $past(fasErrCnt) + 1'b1));

  assert_nfas_alt_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && nfasErrCnt > $past(nfasErrCnt)) |-> $past(altMode));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(bitEn)) |-> ($stable(inSync) && !frameStart));

endmodule

bind e1_frame_aligner e1_frame_aligner_chk #(.ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .altMode(altMode),
  .inSync(inSync), .lossOfSync(lossOfSync), .frameStart(frameStart),
  .fasFrame(fasFrame), .fasErrCnt(fasErrCnt), .nfasErrCnt(nfasErrCnt)
);

// File: tb/e1_frame_aligner_bench.sv
`timescale 1ns/1ps
module e1_frame_aligner_bench;

  localparam int NEVER = 1 << 30;
  localparam int FB = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic rxBit = 1'b0;
  logic altMode = 1'b0;
  logic inSync, lossOfSync, frameStart, fasFrame;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int curO, syncAt, lossAt, resyncAt, lastK;
  int badFas, badNfas;
  string tagIn;

  always #5 clk = ~clk;

  e1_frame_aligner u_e1_frame_aligner (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .altMode(altMode),
    .inSync(inSync), .lossOfSync(lossOfSync), .frameStart(frameStart), .fasFrame(fasFrame)
  );

  function automatic int frameOf(int k);
    return (k - curO + 2 * FB) / FB - 2;
  endfunction

  function automatic int posOf(int k);
    return (k - curO + 2 * FB) % FB;
  endfunction

  // stream model: alignment word 0011011 in bits 2..8 of TS0 of even frames,
  // bit 2 = 1 in odd frames, payload with no two adjacent zeros
  function automatic logic streamBit(int k);
    int f, p;
    logic [6:0] word;
    f = frameOf(k);
    p = posOf(k);
    word = 7'b0011011;
    if (f < 0 || p >= 8) return ((k % 5 == 0) || (k % 5 == 2)) ? 1'b0 : 1'b1;
    if (p == 0) return 1'b1;
    if (f % 2 == 0) begin
      if (p == 7 && f < 16 && badFas[f]) return 1'b0;
      return word[7 - p];
    end
    if (p == 1) return (f < 16 && badNfas[f]) ? 1'b0 : 1'b1;
    if (p == 2) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit expIn(int k);
    if (k < 0) return 1'b0;
    return ((k >= syncAt) && (k < lossAt)) || (k >= resyncAt);
  endfunction

  function automatic int kOf(int f, int p);
    return curO + FB * f + p;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic sendBit(input int k);
    bit e;
    @(negedge clk);
    bitEn = 1'b1;
    rxBit = streamBit(k);
    @(posedge clk);
    #1;
    e = expIn(k);
    chk(inSync == e, tagIn, "inSync", int'(inSync), int'(e));
    chk(lossOfSync == !e, "R10", "lossOfSync", int'(lossOfSync), int'(!e));
    chk(frameStart == ((posOf(k) == 0) && expIn(k - 1)), "R9", "frameStart",
        int'(frameStart), int'((posOf(k) == 0) && expIn(k - 1)));
    chk(fasFrame == (e && (frameOf(k) % 2 == 0)), "R9", "fasFrame",
        int'(fasFrame), int'(e && (frameOf(k) % 2 == 0)));
    lastK = k;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    bitEn = 1'b0;
    rxBit = 1'b0;
    @(posedge clk);
    #1;
    chk(frameStart == 1'b0, "R11", "frameStart idle", int'(frameStart), 0);
    chk(inSync == expIn(lastK), "R11", "inSync idle", int'(inSync), int'(expIn(lastK)));
  endtask

  task automatic runScen(input string tag, input int o, input bit alt, input int bf, input int bn,
                         input int nFrames, input int sF, input int lF, input int rF, input int gap);
    curO = o; badFas = bf; badNfas = bn; tagIn = tag; lastK = -1;
    syncAt   = (sF < 0) ? NEVER : kOf(sF, 7);
    lossAt   = (lF < 0) ? NEVER : kOf(lF, 7);
    resyncAt = (rF < 0) ? NEVER : kOf(rF, 7);
    @(negedge clk);
    rstN = 1'b0; bitEn = 1'b0; altMode = alt;
    repeat (2) @(negedge clk);
    chk(inSync == 1'b0 && lossOfSync == 1'b1 && frameStart == 1'b0 && fasFrame == 1'b0,
        "R1", "reset outputs", int'({inSync, lossOfSync, frameStart, fasFrame}), 4);
    rstN = 1'b1;
    for (int k = 0; k < o + FB * nFrames; k++) begin
      sendBit(k);
      if (gap > 0 && (k % gap) == gap - 1) idleCycle();
    end
  endtask

  initial begin
    // R2: acquisition across start offsets, both modes
    runScen("R2", 0,   1'b0, 0, 0, 5, 2, -1, -1, 0);
    runScen("R2", 1,   1'b1, 0, 0, 5, 2, -1, -1, 0);
    runScen("R2", 37,  1'b0, 0, 0, 5, 2, -1, -1, 0);
    runScen("R2", 128, 1'b1, 0, 0, 5, 2, -1, -1, 0);
    runScen("R2", 200, 1'b0, 0, 0, 5, 2, -1, -1, 0);
    runScen("R2", 255, 1'b1, 0, 0, 5, 2, -1, -1, 0);
    // R3: frame N+1 bit 2 wrong, next candidate is frame 2
    runScen("R3", 90,  1'b0, 0, 16'h0002, 6, 4, -1, -1, 0);
    // R4: frame N+2 word wrong, next candidate is frame 4
    runScen("R4", 11,  1'b1, 16'h0004, 0, 8, 6, -1, -1, 0);
    // R5: three bad alignment words in a row
    runScen("R5", 50,  1'b0, 16'h0150, 0, 14, 2, 8, 12, 0);
    // R6: error run interrupted by a good word
    runScen("R6", 73,  1'b1, 16'h1450, 0, 15, 2, -1, -1, 0);
    // R7: bit-2 errors ignored with altMode clear
    runScen("R7", 140, 1'b0, 0, 16'h02A0, 12, 2, -1, -1, 0);
    // R8: bit-2 errors drop lock with altMode set
    runScen("R8", 140, 1'b1, 0, 16'h02A0, 14, 2, 9, 12, 0);
    // R6: bit-2 error run interrupted by a good frame
    runScen("R6", 5,   1'b1, 0, 16'h28A0, 15, 2, -1, -1, 0);
    // R11: idle cycles interleaved, plus a loss and relock
    runScen("R11", 77, 1'b0, 16'h0150, 0, 14, 2, 8, 12, 7);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule